// File: doc/BRIEF.md
# Program Exception Entry Unit

This unit performs entry into a program-class exception for a simple in-order processor core. It receives the current machine state word, the effective address of the instruction in flight, and the cause indications for the instruction. These are an illegal-instruction flag, a privileged-class flag, a special-register-move flag with the top bit of its register selector, a trap outcome, and a flag saying the saved address points past the faulting instruction. When a cause qualifies and no higher-priority exception is pending, the unit does the following in a single clock edge. It captures the two save/restore words, produces the rewritten machine state word, and presents the redirect vector.

All 32-bit words use big-endian bit numbering: bit 0 is the most significant bit, so big-endian bit k is vector index 31-k. Machine-state fields used here, by big-endian position: POW 13, ILE 15, EE 16, PR 17, FP 18, ME 19, SE 21, BE 22, IP 25, IR 26, DR 27, RI 30, LE 31. The surrounding core consumes `msr_o` when `taken_o` pulses, and fetches from `vector_o`.

Top module: `prog_exc_entry`

## Requirements
- R1: When an effective cause is present at a rising edge and `hp_pending_i` is 0, `taken_o` is 1 for the following cycle; otherwise `taken_o` is 0.
- R2: The privileged cause is effective only when MSR bit PR (big-endian 17) is 1, and then if `privop_i` is 1 or both `sprmove_i` and `sprtop_i` are 1; with PR at 0 these inputs cause nothing.
- R3: With `hp_pending_i` at 1 no entry happens: `taken_o` stays 0 and `srr0_o`, `srr1_o`, `msr_o`, `vector_o` keep their values.
- R4: On entry `srr0_o` becomes `ea_i`.
- R5: On entry `srr1_o` big-endian bits 0, 5 to 9 and 16 to 31 equal the same MSR bits, and big-endian bits 1 to 4, 10 and 11 are 0.
- R6: `srr1_o` big-endian bit 12 marks illegal, 13 privileged, 14 trap. Exactly one is set, with priority illegal over privileged over trap.
- R7: `srr1_o` big-endian bit 15 equals `later_addr_i`.
- R8: On entry `msr_o` equals the MSR with POW, EE, PR, FP, SE, BE, IR, DR and RI cleared and LE set to ILE. All other bits, including ILE, ME and IP, are unchanged.
- R9: On entry `vector_o` is 0x00000700 when MSR IP is 0, and 0xFFF00700 when it is 1.
- R10: `multi_cause_o` is 1 in the cycle after an entry in which more than one effective cause was present, and 0 otherwise.
- R11: Synchronous reset clears all outputs to 0, and with no entry the output words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msr_i | input | 32 | Current machine state word |
| ea_i | input | 32 | Effective address to be saved |
| illegal_i | input | 1 | Illegal-instruction cause |
| privop_i | input | 1 | Decoded instruction is privileged-class |
| sprmove_i | input | 1 | Decoded instruction moves to/from a special register |
| sprtop_i | input | 1 | Top bit of the special-register selector |
| trap_i | input | 1 | Trap condition met |
| later_addr_i | input | 1 | Saved address is of a later instruction |
| hp_pending_i | input | 1 | Higher-priority exception pending, suppresses entry |
| taken_o | output | 1 | Entry happened on the last edge |
| srr0_o | output | 32 | Saved address word |
| srr1_o | output | 32 | Saved status word |
| msr_o | output | 32 | Rewritten machine state word |
| vector_o | output | 32 | Redirect fetch address |
| multi_cause_o | output | 1 | More than one cause was present at entry |

## Verification
Two functions can collide in one cycle. The first is cause arbitration, when illegal, privileged and trap are raised together. The second is higher-priority suppression, when a cause arrives together with `hp_pending_i`. Vectors drive several causes at once and expect a single cause bit by priority, with `multi_cause_o` raised. Other vectors pair a cause with the pending flag and expect no pulse and unchanged saved words. The privileged cause is also exercised in supervisor mode, where it must vanish, so that suppression by mode is told apart from suppression by priority.

// File: rtl/prog_exc_pkg.sv
package prog_exc_pkg;

    localparam int XLEN = 32;
    typedef logic [XLEN-1:0] word_t;

    // big-endian field positions in the machine state word
    localparam int BP_POW = 13;
    localparam int BP_ILE = 15;
    localparam int BP_EE  = 16;
    localparam int BP_PR  = 17;
    localparam int BP_FP  = 18;
    localparam int BP_SE  = 21;
    localparam int BP_BE  = 22;
    localparam int BP_IP  = 25;
    localparam int BP_IR  = 26;
    localparam int BP_DR  = 27;
    localparam int BP_RI  = 30;
    localparam int BP_LE  = 31;

    // big-endian positions of the cause field in the saved status word
    localparam int SB_ILL   = 12;
    localparam int SB_PRIV  = 13;
    localparam int SB_TRAP  = 14;
    localparam int SB_LATER = 15;

    typedef enum logic [1:0] {
        CS_NONE = 2'd0,
        CS_ILL  = 2'd1,
        CS_PRIV = 2'd2,
        CS_TRAP = 2'd3
    } cause_sel_e;

    typedef struct packed {
        logic ill;
        logic priv;
        logic trap;
    } cause_t;

    typedef struct packed {
        word_t srr0;
        word_t srr1;
        word_t msr;
        word_t vec;
        logic  multi;
    } entry_t;

    function automatic int be_pos(input int k);
        return XLEN - 1 - k;
    endfunction

    // bits copied from the machine state into the saved status word
    function automatic word_t srr1_copy_mask();
        word_t m;
        m = '0;
        for (int k = 0; k < XLEN; k++) begin
            if (k == 0 || (k >= 5 && k <= 9) || k >= 16)
                m[XLEN-1-k] = 1'b1;
        end
        return m;
    endfunction

    // machine state bits forced to zero on entry (LE is then refilled)
    function automatic word_t msr_clear_mask();
        word_t m;
        m = '0;
        m[be_pos(BP_POW)] = 1'b1;
        m[be_pos(BP_EE)]  = 1'b1;
        m[be_pos(BP_PR)]  = 1'b1;
        m[be_pos(BP_FP)]  = 1'b1;
        m[be_pos(BP_SE)]  = 1'b1;
        m[be_pos(BP_BE)]  = 1'b1;
        m[be_pos(BP_IR)]  = 1'b1;
        m[be_pos(BP_DR)]  = 1'b1;
        m[be_pos(BP_RI)]  = 1'b1;
        m[be_pos(BP_LE)]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pe_cause_arb.sv
module pe_cause_arb
    import prog_exc_pkg::*;
(
    input  logic       msr_pr,
    input  logic       illegal,
    input  logic       privop,
    input  logic       sprmove,
    input  logic       sprtop,
    input  logic       trap,
    input  logic       hp_pending,
    output cause_sel_e sel,
    output logic       take,
    output logic       multi
);

    cause_t raw;

    always_comb begin
        raw.ill  = illegal;
        raw.priv = msr_pr & (privop | (sprmove & sprtop));
        raw.trap = trap;
    end

    always_comb begin
        if (raw.ill)       sel = CS_ILL;
        else if (raw.priv) sel = CS_PRIV;
        else if (raw.trap) sel = CS_TRAP;
        else               sel = CS_NONE;
    end

    assign take  = (sel != CS_NONE) & ~hp_pending;
    assign multi = (raw.ill & raw.priv) | (raw.ill & raw.trap) | (raw.priv & raw.trap);

endmodule

// File: rtl/pe_srr1_build.sv
module pe_srr1_build
    import prog_exc_pkg::*;
(
    input  word_t      msr,
    input  cause_sel_e sel,
    input  logic       later,
    output word_t      srr1
);

    localparam word_t COPY_MASK = srr1_copy_mask();
    localparam int    I_ILL     = be_pos(SB_ILL);
    localparam int    I_PRIV    = be_pos(SB_PRIV);
    localparam int    I_TRAP    = be_pos(SB_TRAP);
    localparam int    I_LATER   = be_pos(SB_LATER);

    always_comb begin
        srr1 = msr & COPY_MASK;
        case (sel)
            CS_ILL:  srr1[I_ILL]  = 1'b1;
            CS_PRIV: srr1[I_PRIV] = 1'b1;
            CS_TRAP: srr1[I_TRAP] = 1'b1;
            default: ;
        endcase
        srr1[I_LATER] = later;
    end

endmodule

// File: rtl/pe_msr_rewrite.sv
module pe_msr_rewrite
    import prog_exc_pkg::*;
#(
    parameter word_t VEC_OFFSET = 32'h0000_0700,
    parameter word_t LO_BASE    = 32'h0000_0000,
    parameter word_t HI_BASE    = 32'hFFF0_0000
) (
    input  word_t msr,
    output word_t msr_new,
    output word_t vec
);

    localparam word_t CLR_MASK = msr_clear_mask();
    localparam int    I_ILE    = be_pos(BP_ILE);
    localparam int    I_LE     = be_pos(BP_LE);
    localparam int    I_IP     = be_pos(BP_IP);

    always_comb begin
        msr_new       = msr & ~CLR_MASK;
        msr_new[I_LE] = msr[I_ILE];
        vec           = (msr[I_IP] ? HI_BASE : LO_BASE) | VEC_OFFSET;
    end

endmodule

// File: rtl/prog_exc_entry.sv
module prog_exc_entry
    import prog_exc_pkg::*;
#(
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0700,
    parameter logic [31:0] HI_BASE    = 32'hFFF0_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] msr_i,
    input  logic [31:0] ea_i,
    input  logic        illegal_i,
    input  logic        privop_i,
    input  logic        sprmove_i,
    input  logic        sprtop_i,
    input  logic        trap_i,
    input  logic        later_addr_i,
    input  logic        hp_pending_i,
    output logic        taken_o,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] msr_o,
    output logic [31:0] vector_o,
    output logic        multi_cause_o
);

    localparam int I_PR = be_pos(BP_PR);

    cause_sel_e sel;
    logic       take;
    logic       multi;
    word_t      srr1_d;
    word_t      msr_d;
    word_t      vec_d;
    entry_t     ent_q;
    logic       taken_q;

    pe_cause_arb u_arb (
        .msr_pr     (msr_i[I_PR]),
        .illegal    (illegal_i),
        .privop     (privop_i),
        .sprmove    (sprmove_i),
        .sprtop     (sprtop_i),
        .trap       (trap_i),
        .hp_pending (hp_pending_i),
        .sel        (sel),
        .take       (take),
        .multi      (multi)
    );

    pe_srr1_build u_srr1 (
        .msr   (msr_i),
        .sel   (sel),
        .later (later_addr_i),
        .srr1  (srr1_d)
    );

    pe_msr_rewrite #(
        .VEC_OFFSET (VEC_OFFSET),
        .LO_BASE    ('0),
        .HI_BASE    (HI_BASE)
    ) u_msr (
        .msr     (msr_i),
        .msr_new (msr_d),
        .vec     (vec_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q   <= '0;
            taken_q <= 1'b0;
        end else begin
            taken_q     <= take;
            ent_q.multi <= take & multi;
            if (take) begin
                ent_q.srr0 <= ea_i;
                ent_q.srr1 <= srr1_d;
                ent_q.msr  <= msr_d;
                ent_q.vec  <= vec_d;
            end
        end
    end

    assign taken_o       = taken_q;
    assign srr0_o        = ent_q.srr0;
    assign srr1_o        = ent_q.srr1;
    assign msr_o         = ent_q.msr;
    assign vector_o      = ent_q.vec;
    assign multi_cause_o = ent_q.multi;

endmodule

// File: rtl/prog_exc_entry_chk.sv
module prog_exc_entry_chk
    import prog_exc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] ea_i,
    input logic        illegal_i,
    input logic        trap_i,
    input logic        hp_pending_i,
    input logic        taken_o,
    input logic [31:0] srr0_o,
    input logic [31:0] srr1_o,
    input logic [31:0] msr_o,
    input logic [31:0] vector_o,
    input logic        multi_cause_o
);

    // R1
    illegal_take_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_i && !hp_pending_i) |=> taken_o);

    // R3
    hp_block_chk: assert property (@(posedge clk) disable iff (rst)
        hp_pending_i |=> !taken_o);

    // R4
    srr0_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_i && !hp_pending_i) |=> (srr0_o == $past(ea_i)));

    // R5
    srr1_zero_chk: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (srr1_o[30:27] == 4'b0 && srr1_o[21:20] == 2'b0));

    // R6
    one_cause_chk: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> ($countones(srr1_o[19:17]) == 1));

    // R8
    msr_le_chk: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (msr_o[be_pos(BP_LE)] == msr_o[be_pos(BP_ILE)]
                     && !msr_o[be_pos(BP_PR)] && !msr_o[be_pos(BP_EE)]));

    // R9
    vec_offset_chk: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (vector_o[15:0] == 16'h0700));

    // R10
    multi_flag_chk: assert property (@(posedge clk) disable iff (rst)
        multi_cause_o |-> taken_o);

    // R10
    multi_set_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_i && trap_i && !hp_pending_i) |=> (multi_cause_o && srr1_o[19]));

endmodule

bind prog_exc_entry prog_exc_entry_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .ea_i          (ea_i),
    .illegal_i     (illegal_i),
    .trap_i        (trap_i),
    .hp_pending_i  (hp_pending_i),
    .taken_o       (taken_o),
    .srr0_o        (srr0_o),
    .srr1_o        (srr1_o),
    .msr_o         (msr_o),
    .vector_o      (vector_o),
    .multi_cause_o (multi_cause_o)
);

// File: tb/prog_exc_entry_tb.sv
module prog_exc_entry_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] msr_i = '0;
    logic [31:0] ea_i = '0;
    logic        illegal_i = 1'b0;
    logic        privop_i = 1'b0;
    logic        sprmove_i = 1'b0;
    logic        sprtop_i = 1'b0;
    logic        trap_i = 1'b0;
    logic        later_addr_i = 1'b0;
    logic        hp_pending_i = 1'b0;
    logic        taken_o;
    logic [31:0] srr0_o;
    logic [31:0] srr1_o;
    logic [31:0] msr_o;
    logic [31:0] vector_o;
    logic        multi_cause_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] e_srr0 = '0;
    logic [31:0] e_srr1 = '0;
    logic [31:0] e_msr  = '0;
    logic [31:0] e_vec  = '0;

    always #4 clk = ~clk;

    prog_exc_entry dut_i (
        .clk           (clk),
        .rst           (rst),
        .msr_i         (msr_i),
        .ea_i          (ea_i),
        .illegal_i     (illegal_i),
        .privop_i      (privop_i),
        .sprmove_i     (sprmove_i),
        .sprtop_i      (sprtop_i),
        .trap_i        (trap_i),
        .later_addr_i  (later_addr_i),
        .hp_pending_i  (hp_pending_i),
        .taken_o       (taken_o),
        .srr0_o        (srr0_o),
        .srr1_o        (srr1_o),
        .msr_o         (msr_o),
        .vector_o      (vector_o),
        .multi_cause_o (multi_cause_o)
    );

    // stimulus: {msr, ea, hp, ill, priv, sprmove, sprtop, trap, later}
    localparam int NV = 14;
    localparam logic [70:0] VECS [NV] = '{
        {32'h0000_4000, 32'h0000_1000, 7'b0100000},  // user, illegal
        {32'h0000_4000, 32'h0000_1004, 7'b0010000},  // user, privileged op
        {32'h0000_0000, 32'h0000_2000, 7'b0010000},  // supervisor, privileged op: nothing
        {32'hFFFF_FFFF, 32'h0000_2004, 7'b0001100},  // user, spr move top=1
        {32'hFFFF_BFFF, 32'h0000_2008, 7'b0001100},  // supervisor, spr move: nothing
        {32'hFFFF_FFFF, 32'h0000_200C, 7'b0001000},  // user, spr move top=0: nothing
        {32'hFFFF_BFFF, 32'h8000_0000, 7'b0000011},  // trap, later address
        {32'h5A5A_5A5A, 32'hDEAD_BEEC, 7'b0000010},  // trap, mixed state
        {32'h0000_4000, 32'h0000_3000, 7'b0110010},  // three causes
        {32'h0000_4000, 32'h0000_3004, 7'b0010010},  // privileged and trap
        {32'hFFFF_FFFF, 32'h0000_3008, 7'b1100000},  // pending blocks illegal
        {32'h0000_0000, 32'h0000_300C, 7'b0000000},  // idle
        {32'hFFFF_BFFF, 32'h0000_4000, 7'b0100001},  // supervisor illegal, later
        {32'h0001_0040, 32'h0000_4004, 7'b0000010}   // ILE=1 IP=1 trap
    };

    function automatic int bx(input int k);
        return 31 - k;
    endfunction

    function automatic logic [31:0] ref_msr(input logic [31:0] m);
        logic [31:0] r;
        r = m;
        r[bx(13)] = 1'b0; r[bx(16)] = 1'b0; r[bx(17)] = 1'b0;
        r[bx(18)] = 1'b0; r[bx(21)] = 1'b0; r[bx(22)] = 1'b0;
        r[bx(26)] = 1'b0; r[bx(27)] = 1'b0; r[bx(30)] = 1'b0;
        r[bx(31)] = m[bx(15)];
        return r;
    endfunction

    function automatic logic [31:0] ref_srr1(input logic [31:0] m, input int cause,
                                            input logic later);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 32; k++)
            if (k == 0 || (k >= 5 && k <= 9) || k >= 16) r[bx(k)] = m[bx(k)];
        if (cause == 1) r[bx(12)] = 1'b1;
        if (cause == 2) r[bx(13)] = 1'b1;
        if (cause == 3) r[bx(14)] = 1'b1;
        r[bx(15)] = later;
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] m, input logic [31:0] ea, input logic [6:0] s);
        msr_i = m; ea_i = ea;
        {hp_pending_i, illegal_i, privop_i, sprmove_i, sprtop_i, trap_i, later_addr_i} = s;
    endtask

    // apply one vector at a falling edge and check after the next rising edge
    task automatic run_vec(input logic [31:0] m, input logic [31:0] ea, input logic [6:0] s);
        logic pr, ill, prv, trp, tk;
        int   cause, n;
        drive(m, ea, s);
        pr    = m[bx(17)];
        ill   = s[5];
        prv   = pr & (s[4] | (s[3] & s[2]));   // R2
        trp   = s[1];
        n     = int'(ill) + int'(prv) + int'(trp);
        cause = ill ? 1 : (prv ? 2 : (trp ? 3 : 0));
        tk    = (cause != 0) && !s[6];
        if (tk) begin
            e_srr0 = ea;
            e_srr1 = ref_srr1(m, cause, s[0]);
            e_msr  = ref_msr(m);
            e_vec  = (m[bx(25)] ? 32'hFFF0_0000 : 32'h0) | 32'h700;
        end
        @(posedge clk);
        @(negedge clk);
        check("R1/R2/R3 taken", {31'b0, taken_o}, {31'b0, tk});
        check("R4/R11 srr0", srr0_o, e_srr0);
        check("R5/R6/R7 srr1", srr1_o, e_srr1);
        check("R8/R11 msr", msr_o, e_msr);
        check("R9 vector", vector_o, e_vec);
        check("R10 multi", {31'b0, multi_cause_o}, {31'b0, tk && n > 1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 reset taken", {31'b0, taken_o}, 32'h0);
        check("R11 reset srr0", srr0_o, 32'h0);
        check("R11 reset srr1", srr1_o, 32'h0);
        check("R11 reset msr", msr_o, 32'h0);
        check("R11 reset vec", vector_o, 32'h0);

        for (int i = 0; i < NV; i++)
            run_vec(VECS[i][70:39], VECS[i][38:7], VECS[i][6:0]);

        // R3 pending with every cause: saved words must hold
        run_vec(32'h0000_4000, 32'h0000_5000, 7'b1110111);
        // R6 privileged beats trap via spr move path
        run_vec(32'h0000_4000, 32'h0000_5004, 7'b0001110);
        // R11 hold across idle cycles
        run_vec(32'h1234_5678, 32'h0000_5008, 7'b0000000);
        run_vec(32'h0000_0000, 32'h0000_500C, 7'b0000001);

        // R11 reset after an entry clears everything
        run_vec(32'hFFFF_FFFF, 32'h0000_6000, 7'b0100000);
        drive(32'h0, 32'h0, 7'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_srr0 = '0; e_srr1 = '0; e_msr = '0; e_vec = '0;
        check("R11 reset srr0 after entry", srr0_o, 32'h0);
        check("R11 reset srr1 after entry", srr1_o, 32'h0);
        check("R11 reset vec after entry", vector_o, 32'h0);
        run_vec(32'h0000_0040, 32'h0000_7000, 7'b0000010);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule